// File: doc/BRIEF.md
# Source Alignment Discontinuity Handler

This block sits beside one DMA channel thread and watches every write to the channel's source-address register. It keeps a copy of the byte-lane alignment bits of the most recent source address. The alignment bits are the low log2(DATA_W/8) bits of the address: two bits for a 32-bit bus and three bits for a 64-bit bus. When a write changes those bits, the source data stream is no longer continuous. The block then stalls the channel sequencer. It waits until every read the channel still has in flight has returned, which works like a read barrier, and then lets the thread continue.

The block counts the channel's outstanding reads from two event pulses: one when a read is issued and one when a read response completes. Buffered data in the shared data FIFO is never flushed or discarded. The block has no path to that storage at all. It only holds the sequencer back.

The sequence moves through four named states:
- **RUN**: normal execution.
- **HALT**: a single cycle in which the thread is frozen.
- **DRAIN**: the thread stays stalled until the outstanding count is zero.
- **RESUME**: a single cycle with the stall released, before returning to RUN.

The transitions are:
- RUN→HALT and RESUME→HALT on a discontinuity.
- HALT→DRAIN always.
- DRAIN→RESUME once the count is seen at zero.
- RESUME→RUN when no discontinuity arrives.

Top module: `src_align_guard`

## Requirements
- R1: After reset, `stall` is 0, `phase` is 0 (RUN) and `rd_pending` is 0.
- R2: `rd_pending` rises by one for each cycle with `rd_issue` alone, falls by one for each cycle with `rd_done` alone, and is unchanged when both or neither are high.
- R3: A source-address write in RUN or RESUME whose low ALIGN_W bits (bits [1:0] for DATA_W=32) differ from the tracked alignment moves `phase` to 1 (HALT) and raises `stall` in the cycle after the write.
- R4: A source-address write whose low ALIGN_W bits equal the tracked alignment does not stall the channel, whatever the upper address bits are.
- R5: HALT lasts exactly one cycle and is always followed by DRAIN (`phase` = 2), with `stall` held high.
- R6: DRAIN keeps `stall` high while `rd_pending` is nonzero. It moves to RESUME in the cycle after `rd_pending` is seen at zero, including when the count is already zero on entry.
- R7: RESUME (`phase` = 3) lasts one cycle with `stall` low, then returns to RUN unless a discontinuity is written in that cycle.
- R8: The tracked alignment resets to zero and takes the low ALIGN_W bits of every source-address write, so each comparison is against the most recent write.
- R9: A source-address write during HALT or DRAIN updates the tracked alignment but neither restarts nor lengthens the stall sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sa_wr_en | input | 1 | Source-address register write strobe |
| sa_wr_addr | input | ADDR_W | Source address being written |
| rd_issue | input | 1 | One read issued by the channel this cycle |
| rd_done | input | 1 | One read response completed this cycle |
| stall | output | 1 | Hold the channel sequencer |
| phase | output | 2 | Current state: 0 RUN, 1 HALT, 2 DRAIN, 3 RESUME |
| rd_pending | output | CNT_W | Number of outstanding reads |

## Verification
The embedded assertions check these properties on every cycle:
- a discontinuity seen in RUN or RESUME is always followed by HALT;
- HALT always leads to DRAIN;
- DRAIN never exits while reads are still outstanding;
- a write with unchanged alignment never produces a stall;
- the read counter steps by exactly one.

The bench scenarios show the timing and the tracked-alignment behaviour. This covers the exact number of stalled cycles for a given completion timing and the immediate exit when nothing is outstanding. It also covers writes arriving mid-drain, which are folded into the tracked alignment without extending the stall, and a back-to-back discontinuity taken from RESUME.

// File: rtl/sag_pkg.sv
package sag_pkg;

    typedef enum logic [1:0] {
        PH_RUN    = 2'd0,
        PH_HALT   = 2'd1,
        PH_DRAIN  = 2'd2,
        PH_RESUME = 2'd3
    } sag_phase_e;

    function automatic int unsigned lane_bits(input int unsigned data_w);
        return $clog2(data_w / 8);
    endfunction

endpackage

// File: rtl/sag_align_track.sv
module sag_align_track #(
    parameter int unsigned ALIGN_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ALIGN_W-1:0] wr_lane,
    output logic               disc,
    output logic [ALIGN_W-1:0] align_q
);

    logic [ALIGN_W-1:0] lane_diff;

    // per-lane-bit comparison against the tracked alignment
    for (genvar b = 0; b < ALIGN_W; b++) begin : g_cmp
        assign lane_diff[b] = wr_lane[b] ^ align_q[b];
    end

    assign disc = wr_en && (|lane_diff);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            align_q <= '0;
        end else if (wr_en) begin
            align_q <= wr_lane;
        end
    end

    // R8: tracked alignment follows the most recent write
    p_track_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> align_q == $past(wr_lane));

    p_track_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(align_q));

endmodule

// File: rtl/sag_rd_count.sv
module sag_rd_count #(
    parameter int unsigned MAX_OUT = 16,
    parameter int unsigned CNT_W   = $clog2(MAX_OUT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_issue,
    input  logic             rd_done,
    output logic [CNT_W-1:0] count,
    output logic             empty
);

    logic [CNT_W-1:0] count_nx;

    always_comb begin
        count_nx = count;
        unique case ({rd_issue, rd_done})
            2'b10:   count_nx = count + CNT_W'(1);
            2'b01:   count_nx = count - CNT_W'(1);
            default: count_nx = count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= count_nx;
        end
    end

    assign empty = (count == '0);

    // R2: single-step counting, no wrap in either direction
    p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_issue && !rd_done) |=> count == $past(count) + CNT_W'(1));

    p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !rd_issue) |=> count == $past(count) - CNT_W'(1));

    p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !(rd_done && !rd_issue));

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_W'(MAX_OUT)) |-> !(rd_issue && !rd_done));

endmodule

// File: rtl/sag_seq_fsm.sv
module sag_seq_fsm
    import sag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       disc,
    input  logic       rd_empty,
    output sag_phase_e state,
    output logic       stall
);

    sag_phase_e state_nx;

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            PH_RUN:    state_nx = disc ? PH_HALT : PH_RUN;
            PH_HALT:   state_nx = PH_DRAIN;
            PH_DRAIN:  state_nx = rd_empty ? PH_RESUME : PH_DRAIN;
            PH_RESUME: state_nx = disc ? PH_HALT : PH_RUN;
            default:   state_nx = PH_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PH_RUN;
        end else begin
            state <= state_nx;
        end
    end

    // outputs
    always_comb begin
        stall = 1'b0;
        unique case (state)
            PH_RUN:    stall = 1'b0;
            PH_HALT:   stall = 1'b1;
            PH_DRAIN:  stall = 1'b1;
            PH_RESUME: stall = 1'b0;
            default:   stall = 1'b0;
        endcase
    end

    p_enter_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == PH_RUN || state == PH_RESUME) && disc) |=> state == PH_HALT);

    p_halt_to_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state == PH_HALT |=> (state == PH_DRAIN && stall));

    p_drain_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_DRAIN && !rd_empty) |=> (state == PH_DRAIN && stall));

    p_drain_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_DRAIN && rd_empty) |=> state == PH_RESUME);

    p_resume_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_RESUME && !disc) |=> state == PH_RUN);

    // R9: writes while stalled never send the sequence back to HALT
    p_no_rehalt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state == PH_DRAIN |=> state != PH_HALT);

endmodule

// File: rtl/src_align_guard.sv
module src_align_guard
    import sag_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned MAX_OUT = 16,
    parameter int unsigned CNT_W   = $clog2(MAX_OUT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sa_wr_en,
    input  logic [ADDR_W-1:0] sa_wr_addr,
    input  logic              rd_issue,
    input  logic              rd_done,
    output logic              stall,
    output logic [1:0]        phase,
    output logic [CNT_W-1:0]  rd_pending
);

    localparam int unsigned ALIGN_W = lane_bits(DATA_W);

    logic               disc;
    logic [ALIGN_W-1:0] align_q;
    logic               rd_empty;
    sag_phase_e         state;

    sag_align_track #(
        .ALIGN_W (ALIGN_W)
    ) u_align (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sa_wr_en),
        .wr_lane (sa_wr_addr[ALIGN_W-1:0]),
        .disc    (disc),
        .align_q (align_q)
    );

    sag_rd_count #(
        .MAX_OUT (MAX_OUT),
        .CNT_W   (CNT_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_issue (rd_issue),
        .rd_done  (rd_done),
        .count    (rd_pending),
        .empty    (rd_empty)
    );

    sag_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .disc     (disc),
        .rd_empty (rd_empty),
        .state    (state),
        .stall    (stall)
    );

    assign phase = state;

    // R4: unchanged alignment never produces a stall
    p_same_lane_no_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == PH_RUN || state == PH_RESUME) && sa_wr_en
         && sa_wr_addr[ALIGN_W-1:0] == align_q) |=> !stall);

    p_addr_known_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sa_wr_en |-> !$isunknown(sa_wr_addr));

endmodule

// File: tb/src_align_guard_tb.sv
module src_align_guard_tb;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned CNT_W  = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sa_wr_en = 1'b0;
    logic [ADDR_W-1:0] sa_wr_addr = '0;
    logic              rd_issue = 1'b0;
    logic              rd_done = 1'b0;
    logic              stall;
    logic [1:0]        phase;
    logic [CNT_W-1:0]  rd_pending;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    // expected: {stall, phase[1:0], pending[4:0]}
    logic [7:0] q_exp[$];
    string      q_tag[$];

    // bench model state, derived from the requirements
    int         m_phase = 0;
    int         m_cnt = 0;
    logic [1:0] m_align = 2'd0;

    always #10 clk = ~clk;

    src_align_guard u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sa_wr_en   (sa_wr_en),
        .sa_wr_addr (sa_wr_addr),
        .rd_issue   (rd_issue),
        .rd_done    (rd_done),
        .stall      (stall),
        .phase      (phase),
        .rd_pending (rd_pending)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: stall/phase/pending actual=%0d/%0d/%0d expected=%0d/%0d/%0d",
                     tag, act[7], act[6:5], act[4:0], exp[7], exp[6:5], exp[4:0]);
        end
    endtask

    // driver: one cycle of stimulus, pushes the outputs expected after the edge
    task automatic step(input string tag, input bit wr, input logic [31:0] addr,
                        input bit iss, input bit dn);
        bit disc;
        int nph;
        @(negedge clk);
        sa_wr_en   = wr;
        sa_wr_addr = addr;
        rd_issue   = iss;
        rd_done    = dn;
        disc = wr && (addr[1:0] != m_align);
        case (m_phase)
            0:       nph = disc ? 1 : 0;
            1:       nph = 2;
            2:       nph = (m_cnt == 0) ? 3 : 2;
            default: nph = disc ? 1 : 0;
        endcase
        if (wr) m_align = addr[1:0];
        m_cnt = m_cnt + (iss ? 1 : 0) - (dn ? 1 : 0);
        m_phase = nph;
        q_exp.push_back({(nph == 1 || nph == 2) ? 1'b1 : 1'b0, 2'(nph), 5'(m_cnt)});
        q_tag.push_back(tag);
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 0, 32'h0, 0, 0);
    endtask

    // monitor: compares after each edge, away from it
    always @(posedge clk) begin
        #5;
        if (q_exp.size() > 0) begin
            logic [7:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            check(t, {stall, phase, rd_pending}, e);
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset", {stall, phase, rd_pending}, 8'h00);

        // R8: tracked alignment starts at zero, first nonzero lane write halts
        step("R8 first write", 1, 32'h0000_1002, 0, 0);
        step("R5 halt", 0, 0, 0, 0);
        step("R6 drain empty", 0, 0, 0, 0);
        step("R7 resume", 0, 0, 0, 0);

        // R2: counting reads
        step("R2 issue", 0, 0, 1, 0);
        step("R2 issue", 0, 0, 1, 0);
        step("R2 issue", 0, 0, 1, 0);
        step("R2 done", 0, 0, 0, 1);
        step("R2 both", 0, 0, 1, 1);
        step("R2 none", 0, 0, 0, 0);

        // R4: same lane bits, different upper bits
        step("R4 same lane", 1, 32'hABCD_0006, 0, 0);
        step("R4 same lane", 1, 32'h1234_567A, 0, 0);
        idle("R4 no stall", 2);

        // R3/R5/R6: discontinuity with two reads in flight
        step("R3 change lane", 1, 32'h0000_0101, 0, 0);
        step("R5 halt", 0, 0, 0, 0);
        step("R6 drain busy", 0, 0, 0, 0);
        step("R6 drain done1", 0, 0, 0, 1);
        step("R6 drain done2", 0, 0, 0, 1);
        step("R6 drain exit", 0, 0, 0, 0);
        step("R7 resume", 0, 0, 0, 0);
        idle("R7 run", 1);

        // R9: writes during HALT and DRAIN update alignment only
        step("R2 issue", 0, 0, 1, 0);
        step("R3 change lane", 1, 32'h0000_0003, 0, 0);
        step("R9 write in halt", 1, 32'h0000_0000, 0, 0);
        step("R9 write in drain", 1, 32'h0000_0002, 0, 0);
        step("R9 drain", 0, 0, 0, 1);
        step("R9 no extension", 0, 0, 0, 0);
        step("R8 same as drain write", 1, 32'h0000_0F02, 0, 0);
        idle("R8 no stall", 2);

        // R3/R7: discontinuity written in the RESUME cycle
        step("R3 change lane", 1, 32'h0000_0000, 0, 0);
        step("R5 halt", 0, 0, 0, 0);
        step("R6 drain empty", 0, 0, 0, 0);
        step("R3 change in resume", 1, 32'h0000_0001, 0, 0);
        step("R5 halt again", 0, 0, 0, 0);
        step("R6 drain empty", 0, 0, 0, 0);
        idle("R7 resume run", 3);

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule